// File: doc/BRIEF.md
# Banked Register and User RAM Map

This block sits behind a byte-wide synchronous host port and turns each access into one of three targets: the timekeeping register file, which lives outside the block and is reached through a register port; a window of directly addressed user RAM; or a second bank of user RAM that can only be reached indirectly. A single bank-select bit, held in the block and loaded through its own strobe, chooses which address map applies. The two RAM regions together hold 242 general-purpose bytes. No byte is reserved for any function.

With bank 0 selected, the 7-bit address space is fully decoded. The low 14 locations go to the register port and the remaining 114 go to direct RAM. With bank 1 selected, the register locations and the lower part of the direct RAM stay in place. The upper part of the space is then replaced by a pointer register and a data window, which together reach 128 extra bytes. Nothing in the block ever stalls an access, so the host can reach the RAM at any time, including while the external time logic is updating.

Top module: `banked_ram_map`

## Requirements
- R1: After reset `bank_o` is 0, `rdata_o` is 0x00 and the indirect pointer is 0. The contents of both RAM regions are not cleared by reset and survive it.
- R2: In either bank, an access to addresses 0x00–0x0D drives `reg_addr_o` with the low four address bits and `reg_wdata_o` with `wdata_i`. It asserts `reg_we_o` for a write or `reg_re_o` for a read in the same cycle. A read returns `reg_rdata_i` on `rdata_o` one cycle later. No other address asserts either strobe.
- R3: In bank 0, addresses 0x0E–0x7F are 114 read/write user RAM bytes.
- R4: In bank 1, addresses 0x0E–0x3F reach the same direct bytes that bank 0 reaches at the same addresses.
- R5: In bank 1, a write to address 0x50 loads `wdata_i[6:0]` into the indirect pointer. A read of 0x50 returns the pointer zero-extended to 8 bits.
- R6: In bank 1, a read or write at address 0x53 accesses the extended byte selected by the pointer. The 128 extended bytes are separate from the direct byte that bank 0 maps at 0x53.
- R7: In bank 1, addresses 0x40–0x7F other than 0x50 and 0x53 read as 0x00, and writes to them change no storage.
- R8: `rdata_o` is registered. It updates on the clock edge that samples `rd_i` and holds its value in cycles without a read.
- R9: An access is accepted every cycle. Back-to-back writes and reads complete with no wait states.
- R10: When `bank_we_i` is high, `bank_o` takes `bank_d_i` on the next edge. When it is low, `bank_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bank_we_i | input | 1 | Load strobe for the bank-select bit |
| bank_d_i | input | 1 | New bank-select value |
| bank_o | output | 1 | Current bank-select bit |
| addr_i | input | 7 | Host address |
| wdata_i | input | 8 | Host write data |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| rdata_o | output | 8 | Registered read data |
| reg_addr_o | output | 4 | Register-file index |
| reg_wdata_o | output | 8 | Register-file write data |
| reg_re_o | output | 1 | Register-file read strobe |
| reg_we_o | output | 1 | Register-file write strobe |
| reg_rdata_i | input | 8 | Register-file read data |

## Verification
The bench targets the places where the two maps overlap or diverge. It reads back through bank 1 a direct byte that was written in bank 0, and it reads address 0x53 in both banks after different data has gone to each. A decoder that ignored the bank bit, or one that aliased the window onto direct RAM, would return the wrong byte. The bench moves the pointer away and back to show that window data follows the pointer. It also writes to an unmapped bank-1 location and then reads that address in bank 0, which catches a write that leaks into direct RAM. Finally, it pulses reset after RAM has been written, to show that the bank bit and pointer clear while the stored bytes remain.

// File: rtl/bank_map_pkg.sv
package bank_map_pkg;
  typedef enum logic [2:0] {
    RG_REG,
    RG_DIRECT,
    RG_PTR,
    RG_WIN,
    RG_NONE
  } region_e;
endpackage

// File: rtl/bank_addr_decode.sv
module bank_addr_decode
  import bank_map_pkg::*;
#(
  parameter int ADDR_W   = 7,
  parameter int NUM_REGS = 14,
  parameter int B1_TOP   = 'h3F,
  parameter int PTR_ADDR = 'h50,
  parameter int WIN_ADDR = 'h53
) (
  input  logic              bank_i,
  input  logic [ADDR_W-1:0] addr_i,
  output region_e           region_o
);
  logic is_reg;
  assign is_reg = addr_i < ADDR_W'(NUM_REGS);

  always_comb begin
    if (is_reg)                            region_o = RG_REG;
    else if (!bank_i)                      region_o = RG_DIRECT;
    else if (addr_i <= ADDR_W'(B1_TOP))    region_o = RG_DIRECT;
    else if (addr_i == ADDR_W'(PTR_ADDR))  region_o = RG_PTR;
    else if (addr_i == ADDR_W'(WIN_ADDR))  region_o = RG_WIN;
    else                                   region_o = RG_NONE;
  end

  // R2
  always_comb begin
    reg_region_chk: assert (!(region_o == RG_REG) || is_reg);
  end
endmodule

// File: rtl/user_ram.sv
module user_ram #(
  parameter int DEPTH  = 114,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  // Storage is kept across reset to model retained contents.
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[idx_i] <= wdata_i;
  end

  assign rdata_o = mem_q[idx_i];

  // R3
  ram_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(idx_i)] == $past(wdata_i));
endmodule

// File: rtl/banked_ram_map.sv
module banked_ram_map
  import bank_map_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 8,
  parameter int NUM_REGS  = 14,
  parameter int EXT_DEPTH = 128,
  parameter int B1_TOP    = 'h3F,
  parameter int PTR_ADDR  = 'h50,
  parameter int WIN_ADDR  = 'h53,
  localparam int DIR_DEPTH = (1 << ADDR_W) - NUM_REGS,
  localparam int DIR_IW    = $clog2(DIR_DEPTH),
  localparam int PTR_W     = $clog2(EXT_DEPTH),
  localparam int REG_AW    = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bank_we_i,
  input  logic              bank_d_i,
  output logic              bank_o,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [REG_AW-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_re_o,
  output logic              reg_we_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);
  region_e           region;
  logic              bank_q;
  logic [PTR_W-1:0]  ptr_q;
  logic [DATA_W-1:0] dir_rd, ext_rd, rd_mux;
  logic [ADDR_W-1:0] dir_off;
  logic              dir_we, ext_we;

  bank_addr_decode #(
    .ADDR_W  (ADDR_W),
    .NUM_REGS(NUM_REGS),
    .B1_TOP  (B1_TOP),
    .PTR_ADDR(PTR_ADDR),
    .WIN_ADDR(WIN_ADDR)
  ) u_dec (
    .bank_i  (bank_q),
    .addr_i  (addr_i),
    .region_o(region)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        bank_q <= 1'b0;
    else if (bank_we_i) bank_q <= bank_d_i;
  end
  assign bank_o = bank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      ptr_q <= '0;
    else if (wr_i && region == RG_PTR) ptr_q <= wdata_i[PTR_W-1:0];
  end

  assign dir_off = addr_i - ADDR_W'(NUM_REGS);
  assign dir_we  = wr_i && region == RG_DIRECT;
  assign ext_we  = wr_i && region == RG_WIN;

  user_ram #(.DEPTH(DIR_DEPTH), .DATA_W(DATA_W)) u_dir (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (dir_we),
    .idx_i  (dir_off[DIR_IW-1:0]),
    .wdata_i(wdata_i),
    .rdata_o(dir_rd)
  );

  user_ram #(.DEPTH(EXT_DEPTH), .DATA_W(DATA_W)) u_ext (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (ext_we),
    .idx_i  (ptr_q),
    .wdata_i(wdata_i),
    .rdata_o(ext_rd)
  );

  assign reg_addr_o  = addr_i[REG_AW-1:0];
  assign reg_wdata_o = wdata_i;
  assign reg_re_o    = rd_i && region == RG_REG;
  assign reg_we_o    = wr_i && region == RG_REG;

  always_comb begin
    unique case (region)
      RG_REG:    rd_mux = reg_rdata_i;
      RG_DIRECT: rd_mux = dir_rd;
      RG_PTR:    rd_mux = DATA_W'(ptr_q);
      RG_WIN:    rd_mux = ext_rd;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_mux;
  end

  // R10
  bank_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bank_we_i |=> bank_o == $past(bank_d_i));
  // R10
  bank_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bank_we_i |=> $stable(bank_o));
  // R5
  ptr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && bank_o && addr_i == ADDR_W'(PTR_ADDR)) |=> ptr_q == $past(wdata_i[PTR_W-1:0]));
  // R7
  unmapped_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && region == RG_NONE) |=> rdata_o == '0);
  // R7
  unmapped_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && region == RG_NONE) |=> $stable(ptr_q));
  // R8
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
  // R2
  reg_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_re_o || reg_we_o) |-> addr_i < ADDR_W'(NUM_REGS));
endmodule

// File: tb/banked_ram_map_test.sv
module banked_ram_map_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bank_we_i = 1'b0, bank_d_i = 1'b0;
  logic [6:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic       rd_i = 1'b0, wr_i = 1'b0;
  logic       bank_o, reg_re_o, reg_we_o;
  logic [7:0] rdata_o, reg_wdata_o, reg_rdata_i;
  logic [3:0] reg_addr_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;

  always #2 clk_i = ~clk_i;  // 250 MHz

  // Register-file model: returns 0xA0 | index.
  assign reg_rdata_i = {4'hA, reg_addr_o};

  banked_ram_map uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .bank_we_i(bank_we_i), .bank_d_i(bank_d_i),
    .bank_o(bank_o), .addr_i(addr_i), .wdata_i(wdata_i), .rd_i(rd_i), .wr_i(wr_i),
    .rdata_o(rdata_o), .reg_addr_o(reg_addr_o), .reg_wdata_o(reg_wdata_o),
    .reg_re_o(reg_re_o), .reg_we_o(reg_we_o), .reg_rdata_i(reg_rdata_i)
  );

  typedef struct packed {
    logic [3:0] req;
    logic       bank;
    logic       wr;
    logic [6:0] addr;
    logic [7:0] data;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t TBL [NV] = '{
    '{4'd3,  1'b0, 1'b1, 7'h0E, 8'h11},  // R3 write
    '{4'd3,  1'b0, 1'b1, 7'h7F, 8'h22},  // R3
    '{4'd6,  1'b0, 1'b1, 7'h53, 8'h33},  // R6 direct byte at 0x53
    '{4'd7,  1'b0, 1'b1, 7'h40, 8'h5A},  // R7 seed
    '{4'd3,  1'b0, 1'b0, 7'h0E, 8'h11},  // R3 read
    '{4'd3,  1'b0, 1'b0, 7'h7F, 8'h22},  // R3
    '{4'd4,  1'b1, 1'b0, 7'h0E, 8'h11},  // R4 shared
    '{4'd4,  1'b1, 1'b1, 7'h3F, 8'h44},  // R4
    '{4'd4,  1'b0, 1'b0, 7'h3F, 8'h44},  // R4
    '{4'd5,  1'b1, 1'b1, 7'h50, 8'h85},  // R5 ptr <- 5
    '{4'd5,  1'b1, 1'b0, 7'h50, 8'h05},  // R5
    '{4'd6,  1'b1, 1'b1, 7'h53, 8'h66},  // R6 ext[5]
    '{4'd6,  1'b1, 1'b0, 7'h53, 8'h66},  // R6
    '{4'd6,  1'b0, 1'b0, 7'h53, 8'h33},  // R6 separate from direct
    '{4'd7,  1'b1, 1'b1, 7'h40, 8'h77},  // R7 ignored
    '{4'd7,  1'b1, 1'b0, 7'h40, 8'h00},  // R7
    '{4'd7,  1'b0, 1'b0, 7'h40, 8'h5A},  // R7 no leak
    '{4'd7,  1'b1, 1'b0, 7'h7F, 8'h00},  // R7
    '{4'd6,  1'b1, 1'b1, 7'h50, 8'h06},  // R6 ptr <- 6
    '{4'd6,  1'b1, 1'b1, 7'h53, 8'h99},  // R6 ext[6]
    '{4'd6,  1'b1, 1'b1, 7'h50, 8'h05},  // R6 ptr <- 5
    '{4'd6,  1'b1, 1'b0, 7'h53, 8'h66},  // R6 follows ptr
    '{4'd2,  1'b0, 1'b0, 7'h05, 8'hA5},  // R2 reg read bank 0
    '{4'd2,  1'b1, 1'b0, 7'h0D, 8'hAD}   // R2 reg read bank 1
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic bank, input logic wr, input logic [6:0] addr,
                       input logic [7:0] data);
    @(negedge clk_i);
    bank_we_i = 1'b1; bank_d_i = bank; rd_i = 1'b0; wr_i = 1'b0;
    @(negedge clk_i);
    bank_we_i = 1'b0; addr_i = addr; wdata_i = data; wr_i = wr; rd_i = !wr;
    @(negedge clk_i);
    wr_i = 1'b0; rd_i = 1'b0;
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 20000) begin
      n_bad++;
      $display("FAIL R9: watchdog actual %0d cycles expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 bank", {7'd0, bank_o}, 8'h00);
    chk("R1 rdata", rdata_o, 8'h00);
    chk("R1 strobes", {6'd0, reg_re_o, reg_we_o}, 8'h00);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      do_op(TBL[i].bank, TBL[i].wr, TBL[i].addr, TBL[i].data);
      if (!TBL[i].wr) chk($sformatf("R%0d vec %0d", TBL[i].req, i), rdata_o, TBL[i].data);
    end

    // R10 bank bit load and hold
    @(negedge clk_i); bank_we_i = 1'b1; bank_d_i = 1'b1;
    @(negedge clk_i); bank_we_i = 1'b0; bank_d_i = 1'b0;
    chk("R10 load", {7'd0, bank_o}, 8'h01);
    @(negedge clk_i);
    chk("R10 hold", {7'd0, bank_o}, 8'h01);

    // R2 write strobe and fields, same cycle
    @(negedge clk_i); bank_we_i = 1'b1; bank_d_i = 1'b0;
    @(negedge clk_i); bank_we_i = 1'b0; addr_i = 7'h09; wdata_i = 8'hC3; wr_i = 1'b1;
    #1;
    chk("R2 we", {7'd0, reg_we_o}, 8'h01);
    chk("R2 re", {7'd0, reg_re_o}, 8'h00);
    chk("R2 addr", {4'd0, reg_addr_o}, 8'h09);
    chk("R2 wdata", reg_wdata_o, 8'hC3);
    @(negedge clk_i); addr_i = 7'h0E; wdata_i = 8'h11;
    #1;
    chk("R2 no strobe on RAM", {6'd0, reg_re_o, reg_we_o}, 8'h00);

    // R9 back-to-back accesses
    @(negedge clk_i); addr_i = 7'h20; wdata_i = 8'hA1;
    @(negedge clk_i); addr_i = 7'h21; wdata_i = 8'hB2;
    @(negedge clk_i); wr_i = 1'b0; rd_i = 1'b1; addr_i = 7'h20;
    @(negedge clk_i); addr_i = 7'h21;
    chk("R9 first", rdata_o, 8'hA1);
    @(negedge clk_i); rd_i = 1'b0;
    chk("R9 second", rdata_o, 8'hB2);

    // R8 hold while idle
    repeat (3) @(negedge clk_i);
    chk("R8 hold", rdata_o, 8'hB2);

    // R1 reset clears bank and pointer, keeps RAM
    @(negedge clk_i); bank_we_i = 1'b1; bank_d_i = 1'b1;
    @(negedge clk_i); bank_we_i = 1'b0; rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R1 bank after reset", {7'd0, bank_o}, 8'h00);
    chk("R1 rdata after reset", rdata_o, 8'h00);
    rst_ni = 1'b1;
    do_op(1'b1, 1'b0, 7'h50, 8'h00);
    chk("R1 ptr after reset", rdata_o, 8'h00);
    do_op(1'b0, 1'b0, 7'h0E, 8'h00);
    chk("R1 RAM retained", rdata_o, 8'h11);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule